// File: doc/BRIEF.md
# Distributed-Arithmetic Four-Tap Inner Product

This block forms the dot product of four signed samples and four signed weights with no multiplier. Outside logic holds a table of fifteen partial sums, one for every nonzero subset of the four samples. The block walks the weights one bit position per cycle. At each position, the four weight bits form a 4-bit address that picks one table entry. That entry is scaled to the bit position and folded into a carry-save accumulator. After the last position, one carry-propagate add turns the sum and carry words into the result.

A one-cycle `start` strobe launches a computation and captures the weights. The result appears on `y` together with a one-cycle `done` pulse. `y` then keeps its value until the next result. The partial-sum table is not captured, so it must not change while a computation runs. Building the table and adapting the weights are left to neighbouring logic.

Top module: `da4_inner_product`

## Requirements
- R1: While reset is asserted and after it is released, `y` reads 0 and `done` reads 0 until a computation finishes.
- R2: With weights w0..w3 taken as WL-bit two's complement and table entry m holding the sum of the samples x_i for the set bits i of m, `y` equals w0*x0 + w1*x1 + w2*x2 + w3*x3 as an exact signed value of SW+2+WL bits.
- R3: Table entry m (1 to 15) sits at bits [(m-1)*(SW+2) +: SW+2] of `part_sums`. Weight i sits at bits [i*WL +: WL] of `weights`. At each bit position, bit i of the 4-bit table address is that position's bit of weight i.
- R4: The top bit of each weight carries negative weight. The bit position whose address is formed from the weight MSBs subtracts the selected entry, so a weight of -2^(WL-1) yields -2^(WL-1) times its sample.
- R5: A bit position whose 4-bit address is zero contributes nothing, so all-zero weights give `y` = 0.
- R6: `done` is a single-cycle pulse. It rises exactly WL+1 clock cycles after the cycle in which an accepted `start` is sampled, and `y` carries the new result in that same cycle.
- R7: A `start` sampled while a computation is in progress, up to and including the cycle before `done` is high, is ignored. It changes neither the result nor the timing of the running computation.
- R8: Between `done` pulses, `y` holds the last result, whatever the inputs do.
- R9: Extreme operands are exact. When every weight and sample is -2^(WL-1) and -2^(SW-1), `y` is the largest positive value, +65536 at the default widths.
- R10: Weights are captured when `start` is accepted. Changes on `weights` during the computation do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle launch strobe, honoured only when idle |
| part_sums | input | 15*(SW+2) | Packed table of the fifteen nonzero sample subsets, entry m at slot m-1 |
| weights | input | 4*WL | Four packed two's-complement weights, tap 0 in the low slot |
| y | output | SW+2+WL | Signed inner product, held between results |
| done | output | 1 | One-cycle pulse marking a fresh value on `y` |

## Verification
The assertions assume that `start` may arrive at any time but that `part_sums` stays constant from an accepted start until the matching `done`. The latency and hold properties rest on the block accepting a new start only in the idle state. The stimulus builds each table from four samples and holds it for the whole run. It changes only the weights and raises extra starts while a run is in flight, and it loads a new table only after `done` has been observed. The random operands span the full signed range of the samples and weights. Directed cases pin the largest magnitudes, single active taps and all-zero weights.

// File: rtl/da4_pkg.sv
package da4_pkg;
  localparam int unsigned TAPS    = 4;
  localparam int unsigned ENTRIES = (1 << TAPS) - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/da4_slice_select.sv
module da4_slice_select
  import da4_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic [ENTRIES*PW-1:0] table_flat,
  input  logic [TAPS-1:0]       sel,
  output logic [PW-1:0]         pick
);
  logic [PW-1:0] ent [ENTRIES+1];

  // address zero is a hard zero, never stored
  assign ent[0] = '0;

  for (genvar g = 1; g <= ENTRIES; g++) begin : g_ent
    assign ent[g] = table_flat[(g-1)*PW +: PW];
  end

  assign pick = ent[sel];
endmodule

// File: rtl/da4_csa_acc.sv
module da4_csa_acc #(
  parameter int PW   = 10,
  parameter int ACCW = 18,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            neg,
  input  logic [CW-1:0]   shamt,
  input  logic [PW-1:0]   pick,
  output logic [ACCW-1:0] sum_q,
  output logic [ACCW-1:0] carry_q
);
  logic [ACCW-1:0] ext, scaled, addend, maj;
  logic [ACCW-1:0] sum_nx, carry_nx;

  always_comb begin
    ext      = {{(ACCW-PW){pick[PW-1]}}, pick};
    scaled   = ext << shamt;
    // inversion alone gives -v-1; the final adder's carry-in supplies the +1
    addend   = neg ? ~scaled : scaled;
    sum_nx   = sum_q ^ carry_q ^ addend;
    maj      = (sum_q & carry_q) | (sum_q & addend) | (carry_q & addend);
    carry_nx = {maj[ACCW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else if (clr) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else if (en) begin
      sum_q   <= sum_nx;
      carry_q <= carry_nx;
    end
  end
endmodule

// File: rtl/da4_final_add.sv
module da4_final_add #(
  parameter int ACCW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [ACCW-1:0] sum_in,
  input  logic [ACCW-1:0] carry_in,
  output logic [ACCW-1:0] y_q
);
  logic [ACCW-1:0] y_nx;

  always_comb begin
    y_nx = sum_in + carry_in + {{(ACCW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (en) begin
      y_q <= y_nx;
    end
  end
endmodule

// File: rtl/da4_inner_product.sv
module da4_inner_product
  import da4_pkg::*;
#(
  parameter int WL = 8,
  parameter int SW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [ENTRIES*(SW+2)-1:0]     part_sums,
  input  logic [TAPS*WL-1:0]            weights,
  output logic [SW+2+WL-1:0]            y,
  output logic                          done
);
  localparam int PW   = SW + 2;
  localparam int ACCW = PW + WL;
  localparam int CW   = (WL > 1) ? $clog2(WL) : 1;
  localparam logic [CW-1:0] LAST_POS = CW'(WL - 1);

  seq_state_e      st_q, st_nx;
  logic [CW-1:0]   pos_q, pos_nx;
  logic            done_q, done_nx;
  logic            accept, last_pos, acc_en;
  logic [TAPS-1:0] sel;
  logic [PW-1:0]   pick;
  logic [ACCW-1:0] sum_w, carry_w;
  logic [WL-1:0]   wsh_q [TAPS];

  // sequencer: next-state logic
  always_comb begin
    accept   = start && (st_q == ST_IDLE);
    last_pos = (st_q == ST_RUN) && (pos_q == LAST_POS);
    st_nx    = st_q;
    pos_nx   = pos_q;
    done_nx  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_nx  = ST_RUN;
        pos_nx = '0;
      end
      ST_RUN: begin
        pos_nx = pos_q + CW'(1);
        if (last_pos) st_nx = ST_FINAL;
      end
      ST_FINAL: begin
        st_nx   = ST_IDLE;
        done_nx = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // sequencer: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      pos_q  <= pos_nx;
      done_q <= done_nx;
    end
  end

  // per-tap weight shifters, LSB presented first
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic          wsh_en;
    logic [WL-1:0] wsh_nx;

    always_comb begin
      wsh_en = accept || (st_q == ST_RUN);
      wsh_nx = accept ? weights[t*WL +: WL] : (wsh_q[t] >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wsh_q[t] <= '0;
      end else if (wsh_en) begin
        wsh_q[t] <= wsh_nx;
      end
    end

    assign sel[t] = wsh_q[t][0];
  end

  // a zero slice is skipped, except on the sign position which must inject -1
  assign acc_en = (st_q == ST_RUN) && ((sel != '0) || last_pos);

  da4_slice_select #(.PW(PW)) u_select (
    .table_flat (part_sums),
    .sel        (sel),
    .pick       (pick)
  );

  da4_csa_acc #(.PW(PW), .ACCW(ACCW), .CW(CW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .en      (acc_en),
    .neg     (last_pos),
    .shamt   (pos_q),
    .pick    (pick),
    .sum_q   (sum_w),
    .carry_q (carry_w)
  );

  da4_final_add #(.ACCW(ACCW)) u_final (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (st_q == ST_FINAL),
    .sum_in   (sum_w),
    .carry_in (carry_w),
    .y_q      (y)
  );

  assign done = done_q;
endmodule

// File: rtl/da4_inner_product_chk.sv
module da4_inner_product_chk #(
  parameter int WL = 8,
  parameter int SW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 done,
  input logic [SW+2+WL-1:0]   y
);
  localparam int AW = $clog2(WL + 3) + 1;

  logic          busy_q;
  logic [AW-1:0] age_q;
  logic          take;

  assign take = start && (!busy_q || done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      age_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      age_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      age_q  <= '0;
    end else if (busy_q) begin
      age_q  <= age_q + AW'(1);
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_q && age_q == AW'(WL + 1)));

  // R7
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && age_q == AW'(WL + 1)) |-> done);

  // R8
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y));
endmodule

bind da4_inner_product da4_inner_product_chk #(.WL(WL), .SW(SW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .y     (y)
);

// File: tb/test_da4_inner_product.sv
module test_da4_inner_product;
  localparam int WL   = 8;
  localparam int SW   = 8;
  localparam int PW   = SW + 2;
  localparam int ACCW = PW + WL;

  logic                 clk;
  logic                 rst_n;
  logic                 start;
  logic [15*PW-1:0]     part_sums;
  logic [4*WL-1:0]      weights;
  logic [ACCW-1:0]      y;
  logic                 done;

  int n_checks = 0;
  int n_fails  = 0;
  int xs [4];
  int ws [4];

  da4_inner_product #(.WL(WL), .SW(SW)) i_da4_inner_product (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .part_sums (part_sums),
    .weights   (weights),
    .y         (y),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int expected_dot();
    int acc = 0;
    for (int i = 0; i < 4; i++) acc += xs[i] * ws[i];
    return acc;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic load_operands();
    for (int m = 1; m < 16; m++) begin
      int s = 0;
      for (int i = 0; i < 4; i++) if (m[i]) s += xs[i];
      part_sums[(m-1)*PW +: PW] = PW'(s);
    end
    for (int i = 0; i < 4; i++) weights[i*WL +: WL] = WL'(ws[i]);
  endtask

  // disturb: raise a second start and scramble the weight port mid-run
  task automatic run_case(input string req, input bit disturb);
    int exp;
    int held;
    exp = expected_dot();
    @(negedge clk);
    load_operands();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= WL; k++) begin
      @(negedge clk);
      if (disturb && k == 2) begin
        start   = 1'b1;
        weights = $urandom();
      end
      if (disturb && k == 3) start = 1'b0;
      if (k == WL) check("R6 done early", int'(done), 0);
    end
    @(negedge clk);
    check("R6 done at WL+1", int'(done), 1);
    check(req, int'($signed(y)), exp);
    held    = int'($signed(y));
    weights = $urandom();
    xs[0]   = 1;
    for (int m = 1; m < 16; m++) part_sums[(m-1)*PW +: PW] = PW'($urandom());
    @(negedge clk);
    check("R6 done single cycle", int'(done), 0);
    check("R8 y held", int'($signed(y)), held);
  endtask

  function automatic int rs(input int bits);
    int v;
    v = int'($urandom_range((1 << bits) - 1, 0));
    return v - (1 << (bits - 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d47));
    rst_n     = 1'b0;
    start     = 1'b0;
    part_sums = '0;
    weights   = '0;
    repeat (3) @(negedge clk);
    check("R1 y in reset", int'(y), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 y after reset", int'(y), 0);
    check("R1 done after reset", int'(done), 0);

    // R5: all-zero weights
    xs = '{55, -17, 100, -128}; ws = '{0, 0, 0, 0};
    run_case("R5 zero weights", 1'b0);

    // R3: single active tap picks only its own sample
    for (int t = 0; t < 4; t++) begin
      xs = '{11, -23, 37, -49};
      ws = '{0, 0, 0, 0};
      ws[t] = 5;
      run_case("R3 single tap", 1'b0);
    end

    // R4: most negative weight against a positive sample
    xs = '{127, 0, 0, 0}; ws = '{-128, 0, 0, 0};
    run_case("R4 negative weight", 1'b0);
    xs = '{3, -7, 9, 1}; ws = '{-1, -128, 64, -65};
    run_case("R4 mixed signs", 1'b0);

    // R9: extremes
    xs = '{-128, -128, -128, -128}; ws = '{-128, -128, -128, -128};
    run_case("R9 max positive", 1'b0);
    xs = '{127, 127, 127, 127}; ws = '{-128, -128, -128, -128};
    run_case("R9 max negative", 1'b0);
    xs = '{127, 127, 127, 127}; ws = '{127, 127, 127, 127};
    run_case("R9 positive corner", 1'b0);

    // R5: sparse weights leave many zero address slices
    xs = '{90, -90, 45, -45}; ws = '{16, 0, 0, 1};
    run_case("R5 sparse slices", 1'b0);

    // R7 and R10: restart and weight changes during a run
    xs = '{12, -34, 56, -78}; ws = '{9, -10, 11, -12};
    run_case("R7 R10 disturbed run", 1'b1);

    // R2: random operands, some disturbed
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 4; i++) begin
        xs[i] = rs(SW);
        ws[i] = rs(WL);
      end
      run_case(n[2] ? "R7 R10 random disturbed" : "R2 random", n[2]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule